// File: doc/BRIEF.md
# Flash Program Command Sequencer with Two-Stage Burst Queue

This block sits between a CPU write bus and a nonvolatile array and turns a three-step software sequence into program operations. Software first stores a data word to an aligned array location, then writes the program command code, and finally writes a one to the buffer-empty bit of the status register to launch. A launched program enters a two-entry queue. The entry being programmed holds one stage, so a second program can be staged and launched while the first is still in progress.

While programs run, the block drives a high-voltage enable towards the array. When a finished program is followed by a queued program on the same array row, the enable stays high and the next program skips the ramp-up time. In every other case the enable drops for at least one cycle and the next program pays the ramp delay again. The block checks the launch address against a software-set protection limit. It flags sequences that break the rules, keeps those flags until software clears them, and rejects every command until the clock-divider register has been written after reset. The array itself is a behavioural timing stub with a fixed programming latency and a fixed ramp latency.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset the status output reads 0xC0 (bit 7 buffer-empty = 1, bit 6 all-done = 1, bit 5 protection fault = 0, bit 4 access fault = 0, bits 3:0 = 0). The divider output reads 0 and hv_en is low.
- R2: A register write to offset 0 stores bus_wdata[5:0] as the divider value and sets the loaded bit (div_o[6]). Until that bit is set, any array write, command write or launch sets the access fault and no program strobe occurs.
- R3: A valid sequence has three steps. First an array write to an even byte address (bus_arr=1, bus_addr[0]=0). Then a register write of 0x20 to offset 2. Then a register write to offset 3 with bit 7 set. The program strobe pgm_stb is then high for exactly one cycle, in the cycle after the launch write's sampling edge, carrying word address bus_addr[7:1] and the data.
- R4: The limit register at offset 1 takes a word address. If the launch word address is below that limit, the launch sets the protection fault (status bit 5) and no strobe occurs. A word address equal to the limit is programmed normally.
- R5: These actions set the access fault and discard the staged sequence: a command write without staged data, a command code other than 0x20, an odd array address, a second array write before the command, and a launch without a preceding valid command.
- R6: While either fault is set, every array write, command write or launch is rejected and sets the access fault. A status write with bit 5 or bit 4 set clears that fault, and a zero in those bits leaves it unchanged.
- R7: Status bit 7 reads 0 while two launched programs are outstanding, counting the one being programmed, and 1 otherwise. An array write while it reads 0 sets the access fault.
- R8: Status bit 6 reads 0 from the cycle of the first strobe until every launched program has completed. It rises L+1 cycles after the last strobe, where L is that program's latency.
- R9: When a program completes while a same-row program (word address bits [6:3] equal) is already queued, hv_en stays high without a gap. The queued program's latency is PROG_LAT (4): its strobe comes 11 cycles after a ramped predecessor's strobe, and all-done rises 5 cycles after its own strobe.
- R10: A program that starts with hv_en low pays PROG_LAT+RAMP_LAT (10) cycles. This covers a start from idle, and a queued program on a different row, for which hv_en drops for one cycle at the hand-over.
- R11: A launch sampled on the same edge as the completion of the only running program is neither lost nor merged. It starts in the next cycle with hv_en low and a ramped latency, and all-done stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_arr | input | 1 | 1: the write targets the array, 0: the write targets a register |
| bus_addr | input | 8 | Byte address for array writes; bits 1:0 select the register (0 divider, 1 protection limit, 2 command, 3 status) |
| bus_wdata | input | 16 | Write data |
| stat_o | output | 8 | Status: bit 7 buffer-empty, bit 6 all-done, bit 5 protection fault, bit 4 access fault |
| div_o | output | 7 | Bit 6 divider loaded, bits 5:0 divider value |
| hv_en | output | 1 | High-voltage enable to the array |
| pgm_stb | output | 1 | Program strobe for one cycle |
| pgm_addr | output | 7 | Word address of the program in progress |
| pgm_data | output | 16 | Data of the program in progress |

## Verification
Two of this block's functions can fall in the same cycle. One is the queue accepting a new launch, and the other is the queue retiring the program that has just finished. The bench builds this by staging the second program's data and command while the first runs. It counts cycles from the first strobe and drives the launch so that it is sampled on exactly the completion edge. It then checks that the new program strobes in the following cycle with the new address, that hv_en is low, that all-done never rises and that the buffer shows one free stage. It also checks that all-done rises after a full ramped latency.

// File: rtl/fcs_pkg.sv
// Package: shared codes, register offsets and status bit positions for the
// flash program command sequencer. Assumes byte-wide command codes.
package fcs_pkg;
    localparam logic [7:0] CMD_PROG = 8'h20;
    localparam logic [1:0] OFF_DIV  = 2'd0;
    localparam logic [1:0] OFF_PROT = 2'd1;
    localparam logic [1:0] OFF_CMD  = 2'd2;
    localparam logic [1:0] OFF_STAT = 2'd3;
    localparam int ST_CBE = 7;
    localparam int ST_CC  = 6;
    localparam int ST_PV  = 5;
    localparam int ST_AE  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DATA = 2'd1,
        SEQ_CMD  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fcs_cmd_decode.sv
// Command decoder: tracks the data/command/launch write sequence, owns the
// divider, protection limit and both fault flags, and issues queue pushes.
// Assumes the bus delivers at most one write per cycle and DW >= 8.
module fcs_cmd_decode #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DIV_W = 6,
    localparam int WA   = AW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             arr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             buf_free,
    output logic             push,
    output logic [WA-1:0]    push_addr,
    output logic [DW-1:0]    push_data,
    output logic             acc_err,
    output logic             pviol,
    output logic             div_loaded,
    output logic [DIV_W-1:0] div_val
);
    import fcs_pkg::*;

    seq_state_t    seq;
    logic [WA-1:0] lat_addr;
    logic [DW-1:0] lat_data;
    logic [WA-1:0] prot_lim;
    logic          reg_wr, arr_wr, blocked, launch_req, launch_ok, in_prot;
    logic [1:0]    off;

    // Decode the current bus write and decide whether a launch is legal.
    always_comb begin
        reg_wr     = we && !arr;
        arr_wr     = we && arr;
        off        = addr[1:0];
        blocked    = !div_loaded || acc_err || pviol;
        launch_req = reg_wr && (off == OFF_STAT) && wdata[ST_CBE];
        in_prot    = lat_addr < prot_lim;
        launch_ok  = launch_req && !blocked && (seq == SEQ_CMD);
        push       = launch_ok && !in_prot;
    end

    assign push_addr = lat_addr;
    assign push_data = lat_data;

    // Register writes, sequence state and fault flags (later writes win).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq        <= SEQ_IDLE;
            lat_addr   <= '0;
            lat_data   <= '0;
            prot_lim   <= '0;
            acc_err    <= 1'b0;
            pviol      <= 1'b0;
            div_loaded <= 1'b0;
            div_val    <= '0;
        end else begin
            if (reg_wr && off == OFF_DIV) begin
                div_val    <= wdata[DIV_W-1:0];
                div_loaded <= 1'b1;
            end
            if (reg_wr && off == OFF_PROT)
                prot_lim <= wdata[WA-1:0];
            if (reg_wr && off == OFF_STAT) begin
                if (wdata[ST_PV]) pviol   <= 1'b0;
                if (wdata[ST_AE]) acc_err <= 1'b0;
            end
            if (arr_wr) begin
                if (blocked || seq != SEQ_IDLE || !buf_free || addr[0]) begin
                    acc_err <= 1'b1;
                    seq     <= SEQ_IDLE;
                end else begin
                    lat_addr <= addr[AW-1:1];
                    lat_data <= wdata;
                    seq      <= SEQ_DATA;
                end
            end
            if (reg_wr && off == OFF_CMD) begin
                if (blocked || seq != SEQ_DATA || wdata[7:0] != CMD_PROG) begin
                    acc_err <= 1'b1;
                    seq     <= SEQ_IDLE;
                end else begin
                    seq <= SEQ_CMD;
                end
            end
            if (launch_req) begin
                seq <= SEQ_IDLE;
                if (!launch_ok)   acc_err <= 1'b1;
                else if (in_prot) pviol   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcs_burst_fifo.sv
// Burst queue: DEPTH entries of word address and data. The head entry stays
// in place while it is programmed and is retired by pop. Exposes the row of
// the head and of the entry behind it. Assumes no push when full.
module fcs_burst_fifo #(
    parameter int DEPTH = 2,
    parameter int AWD   = 7,
    parameter int DW    = 16,
    parameter int ROWB  = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int RW   = AWD - ROWB
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [AWD-1:0] push_addr,
    input  logic [DW-1:0]  push_data,
    input  logic           pop,
    output logic [AWD-1:0] head_addr,
    output logic [DW-1:0]  head_data,
    output logic [RW-1:0]  head_row,
    output logic [RW-1:0]  next_row,
    output logic [CW-1:0]  count
);
    logic [AWD-1:0] a_mem [DEPTH];
    logic [DW-1:0]  d_mem [DEPTH];
    logic [PW-1:0]  rd, wr;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Present the head entry and the row of the entry queued behind it.
    always_comb begin
        head_addr = a_mem[rd];
        head_data = d_mem[rd];
        head_row  = a_mem[rd][AWD-1:ROWB];
        next_row  = a_mem[inc(rd)][AWD-1:ROWB];
    end

    // Store pushed entries.
    always_ff @(posedge clk) begin
        if (push) begin
            a_mem[wr] <= push_addr;
            d_mem[wr] <= push_data;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd    <= '0;
            wr    <= '0;
            count <= '0;
        end else begin
            if (push) wr <= inc(wr);
            if (pop)  rd <= inc(rd);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fcs_prog_engine.sv
// Program engine: starts the head entry when idle, retires it on done and
// decides whether high voltage stays on for the next queued entry.
// Assumes done arrives only while busy.
module fcs_prog_engine #(
    parameter int DEPTH = 2,
    parameter int RW    = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [RW-1:0] head_row,
    input  logic [RW-1:0] next_row,
    input  logic          done,
    output logic          stb,
    output logic          ramp,
    output logic          pop,
    output logic          hv_en
);
    logic busy, keep;

    // Start, retire and keep-high decisions.
    always_comb begin
        stb  = !busy && (count != '0);
        ramp = !hv_en;
        pop  = busy && done;
        keep = (count > CW'(1)) && (next_row == head_row);
    end

    // Busy state and high-voltage enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            hv_en <= 1'b0;
        end else if (stb) begin
            busy  <= 1'b1;
            hv_en <= 1'b1;
        end else if (pop) begin
            busy  <= 1'b0;
            hv_en <= keep;
        end
    end
endmodule

// File: rtl/fcs_array_stub.sv
// Array timing stub: signals done a fixed number of cycles after a strobe,
// with extra ramp cycles when high voltage was off. PROG_LAT must be >= 1.
module fcs_array_stub #(
    parameter int PROG_LAT = 4,
    parameter int RAMP_LAT = 6,
    localparam int TW = $clog2(PROG_LAT + RAMP_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic ramp,
    output logic done
);
    logic [TW-1:0] cnt;

    assign done = (cnt == TW'(1));

    // Latency down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (stb)           cnt <= ramp ? TW'(PROG_LAT + RAMP_LAT) : TW'(PROG_LAT);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/flash_burst_seq.sv
// Top: flash program command sequencer with a burst queue. It joins the
// decoder, the queue, the engine and the array stub, and assembles the status
// byte. Assumes a synchronous active-low reset and one bus write per cycle.
module flash_burst_seq #(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int DIV_W    = 6,
    parameter int DEPTH    = 2,
    parameter int ROWB     = 3,
    parameter int PROG_LAT = 4,
    parameter int RAMP_LAT = 6,
    localparam int WA      = AW - 1,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int RW      = WA - ROWB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_arr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [7:0]       stat_o,
    output logic [DIV_W:0]   div_o,
    output logic             hv_en,
    output logic             pgm_stb,
    output logic [WA-1:0]    pgm_addr,
    output logic [DW-1:0]    pgm_data
);
    logic             push, pop, done, ramp, acc_err, pviol, div_loaded;
    logic [WA-1:0]    push_addr;
    logic [DW-1:0]    push_data;
    logic [DIV_W-1:0] div_val;
    logic [RW-1:0]    head_row, next_row;
    logic [CW-1:0]    fifo_cnt;

    fcs_cmd_decode #(.AW(AW), .DW(DW), .DIV_W(DIV_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .arr(bus_arr), .addr(bus_addr),
        .wdata(bus_wdata), .buf_free(fifo_cnt < CW'(DEPTH)), .push(push),
        .push_addr(push_addr), .push_data(push_data), .acc_err(acc_err),
        .pviol(pviol), .div_loaded(div_loaded), .div_val(div_val)
    );

    fcs_burst_fifo #(.DEPTH(DEPTH), .AWD(WA), .DW(DW), .ROWB(ROWB)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
        .push_data(push_data), .pop(pop), .head_addr(pgm_addr),
        .head_data(pgm_data), .head_row(head_row), .next_row(next_row),
        .count(fifo_cnt)
    );

    fcs_prog_engine #(.DEPTH(DEPTH), .RW(RW)) u_eng (
        .clk(clk), .rst_n(rst_n), .count(fifo_cnt), .head_row(head_row),
        .next_row(next_row), .done(done), .stb(pgm_stb), .ramp(ramp),
        .pop(pop), .hv_en(hv_en)
    );

    fcs_array_stub #(.PROG_LAT(PROG_LAT), .RAMP_LAT(RAMP_LAT)) u_arr (
        .clk(clk), .rst_n(rst_n), .stb(pgm_stb), .ramp(ramp), .done(done)
    );

    // Status and divider views.
    always_comb begin
        stat_o = {(fifo_cnt < CW'(DEPTH)), (fifo_cnt == '0), pviol, acc_err, 4'b0000};
        div_o  = {div_loaded, div_val};
    end
endmodule

// File: rtl/fcs_checker.sv
// Checker: temporal properties of the sequencer, bound to the top module.
module fcs_checker #(
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_arr,
    input logic [1:0]    reg_off,
    input logic [1:0]    clr_bits,
    input logic          st_cc,
    input logic          st_pv,
    input logic          st_ae,
    input logic          div_ok,
    input logic          hv_en,
    input logic          pgm_stb,
    input logic [CW-1:0] fifo_cnt
);
    logic clr_wr;
    assign clr_wr = bus_we && !bus_arr && (reg_off == 2'd3);

    AST_NO_LAUNCH_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !div_ok |-> !pgm_stb);  // R2
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_stb |=> !pgm_stb);  // R3
    AST_PV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pv && !(clr_wr && clr_bits[1])) |=> st_pv);  // R6
    AST_AE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ae && !(clr_wr && clr_bits[0])) |=> st_ae);  // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));  // R7
    AST_HV_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> !st_cc);  // R8
    AST_HV_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_stb |=> hv_en);  // R10
endmodule

bind flash_burst_seq fcs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_arr(bus_arr),
    .reg_off(bus_addr[1:0]), .clr_bits(bus_wdata[5:4]), .st_cc(stat_o[6]),
    .st_pv(stat_o[5]), .st_ae(stat_o[4]), .div_ok(div_o[DIV_W]),
    .hv_en(hv_en), .pgm_stb(pgm_stb), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_flash_burst_seq.sv
`timescale 1ns/1ps
// Directed bench for flash_burst_seq: one task per scenario.
module sim_flash_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we, bus_arr;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [7:0]  stat_o;
    logic [6:0]  div_o;
    logic        hv_en, pgm_stb;
    logic [6:0]  pgm_addr;
    logic [15:0] pgm_data;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, stb_n = 0, stb_cyc = 0, hv_falls = 0;
    bit hv_prev = 1'b0, finished = 1'b0;

    flash_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_arr(bus_arr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_o(stat_o),
        .div_o(div_o), .hv_en(hv_en), .pgm_stb(pgm_stb),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor, sampled a quarter period after each rising edge.
    always @(posedge clk) begin
        #2;
        if (pgm_stb) begin
            stb_n++;
            stb_cyc = cyc;
        end
        if (hv_prev && !hv_en) hv_falls++;
        hv_prev = hv_en;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus tasks are called at a falling edge and return at the next one.
    task automatic wr_reg(input logic [1:0] off, input logic [7:0] v);
        bus_we = 1'b1; bus_arr = 1'b0; bus_addr = {6'd0, off}; bus_wdata = {8'd0, v};
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_arr(input logic [7:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_arr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 200 && !stat_o[6]; g++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 status after reset", stat_o, 'hC0);
        check("R1 divider after reset", div_o, 0);
        check("R1 hv after reset", hv_en, 0);
    endtask

    task automatic t_divider();
        int n0 = stb_n;
        wr_arr(8'h10, 16'h1111);
        check("R2 array write before divider", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        check("R6 clear access fault", stat_o, 'hC0);
        wr_reg(2'd3, 8'h80);
        check("R2 launch before divider", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        repeat (3) @(negedge clk);
        check("R2 no strobe before divider", stb_n, n0);
        wr_reg(2'd0, 8'h15);
        check("R2 divider loaded", div_o, 'h55);
    endtask

    task automatic t_basic();
        int e, n0 = stb_n;
        wr_arr(8'h10, 16'hA5A5);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd3, 8'h80);
        e = cyc;
        check("R3 strobe after launch", pgm_stb, 1);
        check("R3 strobe address", pgm_addr, 'h08);
        check("R3 strobe data", pgm_data, 'hA5A5);
        check("R8 done low while running", stat_o[6], 0);
        wait_idle();
        check("R10 ramped latency from idle", cyc - e, 11);
        check("R3 single strobe", stb_n, n0 + 1);
    endtask

    task automatic t_protect();
        int n0;
        wr_reg(2'd1, 8'h10);
        n0 = stb_n;
        wr_arr(8'h04, 16'h2222);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd3, 8'h80);
        check("R4 protection fault set", stat_o[5], 1);
        repeat (3) @(negedge clk);
        check("R4 protected launch not started", stb_n, n0);
        wr_reg(2'd3, 8'h00);
        check("R6 zero write keeps fault", stat_o[5], 1);
        wr_arr(8'h40, 16'h4444);
        check("R6 sequence rejected while fault set", stat_o[4], 1);
        wr_reg(2'd3, 8'h30);
        check("R6 both faults cleared", stat_o, 'hC0);
        wr_arr(8'h20, 16'h3333);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd3, 8'h80);
        check("R4 limit word itself is programmed", pgm_stb, 1);
        check("R4 limit word address", pgm_addr, 'h10);
        wait_idle();
        wr_reg(2'd1, 8'h00);
    endtask

    task automatic t_access();
        int n0 = stb_n;
        wr_reg(2'd2, 8'h20);
        check("R5 command without data", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        wr_arr(8'h12, 16'h5555);
        wr_reg(2'd2, 8'h40);
        check("R5 wrong command code", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        wr_reg(2'd3, 8'h80);
        check("R5 discarded sequence cannot launch", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        wr_arr(8'h13, 16'h6666);
        check("R5 odd address", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        wr_arr(8'h14, 16'h7777);
        wr_arr(8'h16, 16'h7778);
        check("R5 second data write", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        wr_arr(8'h14, 16'h8888);
        wr_reg(2'd3, 8'h80);
        check("R5 launch without command", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        repeat (3) @(negedge clk);
        check("R5 no strobe from faulty sequences", stb_n, n0);
        check("R5 status clean afterwards", stat_o, 'hC0);
    endtask

    task automatic t_pair(input bit same_row);
        int e1, s2, f0, base = stb_n;
        logic [7:0] a2 = same_row ? 8'h42 : 8'h80;
        wr_arr(8'h40, 16'h1234);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd3, 8'h80);
        e1 = cyc;
        f0 = hv_falls;
        wr_arr(a2, 16'h5678);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd3, 8'h80);
        check("R7 buffer full with two programs", stat_o[7], 0);
        wr_arr(8'h44, 16'h9999);
        check("R7 data write while full", stat_o[4], 1);
        wr_reg(2'd3, 8'h10);
        for (int g = 0; g < 100 && stb_n < base + 2; g++) @(negedge clk);
        s2 = stb_cyc;
        check("R9 second strobe after ramped first", s2 - e1, 11);
        check("R9 second strobe address", pgm_addr, a2[7:1]);
        check("R9 second strobe data", pgm_data, 'h5678);
        check("R8 done low between programs", stat_o[6], 0);
        if (same_row) check("R9 hv kept high on same row", hv_falls, f0);
        else          check("R10 hv dropped on row change", hv_falls, f0 + 1);
        wait_idle();
        if (same_row) check("R9 short latency without ramp", cyc - s2, 5);
        else          check("R10 ramped latency after row change", cyc - s2, 11);
        check("R7 buffer empty again", stat_o[7], 1);
    endtask

    task automatic t_coincide();
        int e1;
        wr_arr(8'h60, 16'hAAAA);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd3, 8'h80);
        e1 = cyc;
        wr_arr(8'h62, 16'hBBBB);
        wr_reg(2'd2, 8'h20);
        while (cyc < e1 + 10) @(negedge clk);
        wr_reg(2'd3, 8'h80);
        check("R11 new program starts after shared edge", pgm_stb, 1);
        check("R11 new program address", pgm_addr, 'h31);
        check("R11 hv dropped at hand-over", hv_en, 0);
        check("R11 done stays low", stat_o[6], 0);
        check("R11 one stage free", stat_o[7], 1);
        wait_idle();
        check("R11 ramped latency of new program", cyc - (e1 + 11), 11);
    endtask

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_arr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divider();
        t_basic();
        t_protect();
        t_access();
        t_pair(1'b1);
        t_pair(1'b0);
        t_coincide();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule